// File: doc/BRIEF.md
# Flash Command Interface and Write State Machine

This block is the command front end of a page-programmed flash device. The host reaches it only through bus write cycles, each one an address and a data byte. The block decodes these cycles into read-mode changes, page loads, program and erase operations, and erase suspend and resume. It keeps a status register and selects what a read cycle returns.

Program and erase durations come from cycle counters set by parameters. The storage is a small behavioural byte array inside the block. A page of bytes is staged in an internal page buffer and then committed to the array in one operation. Erase fills either one block or the whole array with FFh.

A write cycle is taken on the rising edge of `we_n`. This edge is seen through a synchronizer on the internal clock, and the cycle counts only when `ce_n` is low and `oe_n` is high at the detection point. Read data is combinational from the address and the current read mode. Any command code or sequence position that the block does not accept drops it to read-array mode.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in read-array mode, every array byte reads FFh, and the status byte reads 80h.
- R2: Writing FFh selects read array. Writing 90h selects the identifier, where address bit 0 low returns MFR_ID and high returns DEV_ID. Writing 70h selects status. Writing 75h selects the page buffer, indexed by the low address bits. `dout` is 00h whenever `ce_n` or `oe_n` is high.
- R3: A write cycle is taken at the rising edge of `we_n` only when `ce_n` is low and `oe_n` is high. A strobe with `ce_n` high or `oe_n` low changes nothing.
- R4: Page program works as follows. Write 41h, then PAGE_BYTES data writes, each stored at the low address bits of its address, then D0h. The page given by the upper address bits of the data writes is then replaced by the buffer contents. Other pages keep their contents, and the buffer stays readable through 75h.
- R5: From the confirming write until the operation ends, status bit 7 reads 0 and every read returns the status byte. Bit 7 returns to 1 after PROG_CYC cycles for a program or ERASE_CYC cycles for an erase. The read mode afterwards is status.
- R6: Writing 20h then D0h erases the block addressed by the D0h write to FFh and leaves other blocks unchanged. Writing 20h then 10h erases the whole array.
- R7: The block returns to read-array mode in three cases: an unknown command code, a confirm other than D0h after a page load, or a second erase byte other than D0h or 10h. No operation starts in any of these cases.
- R8: B0h (suspend) and 30h (resume) written while no erase is running or suspended are ignored, and the read mode and status do not change.
- R9: B0h written during an erase suspends it, and status reads C0h (bit 7 ready, bit 6 suspended). While suspended, the only accepted writes are FFh, 70h and 30h. Resume clears bit 6 and runs only the remaining erase count.
- R10: While a program runs, or while an erase runs (except for B0h), every write is discarded.
- R11: If `fail_inject` is high when an operation completes, the array is left unchanged. A program sets status bit 4 and an erase sets status bit 5. Both flags clear when the next operation is confirmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, cycle taken on its rising edge |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data or command code |
| fail_inject | input | 1 | Test input, forces the completing operation to fail |
| dout | output | 8 | Read data for the selected mode |

## Verification
The bench builds the block with ADDR_W=8, PAGE_BYTES=16 and BLOCK_BYTES=64. This gives four blocks of four pages, so a block erase can be checked against an untouched neighbour block. A full page load also stays short. PROG_CYC=40 and ERASE_CYC=80 are long enough to issue a suspend well inside an erase, and to show that a resumed erase takes less than a full erase period. They are still short enough to time every operation cycle by cycle.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int ADDR_W      = 10,
  parameter int PAGE_BYTES  = 128,
  parameter int BLOCK_BYTES = 256,
  parameter int PROG_CYC    = 50,
  parameter int ERASE_CYC   = 100,
  parameter logic [7:0] MFR_ID = 8'hA5,
  parameter logic [7:0] DEV_ID = 8'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              fail_inject,
  output logic [7:0]        dout
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PG_W  = $clog2(PAGE_BYTES);
  localparam int BK_W  = $clog2(BLOCK_BYTES);
  localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_CONF, S_ESEL, S_PROG, S_ERASE, S_SUSP} st_t;
  typedef enum logic [1:0] {M_ARR, M_ID, M_STAT, M_BUF} md_t;

  st_t                     st;
  md_t                     md;
  logic [CNT_W-1:0]        cnt;
  logic [PG_W-1:0]         lcnt;
  logic [ADDR_W-PG_W-1:0]  page_q;
  logic [ADDR_W-BK_W-1:0]  blk_q;
  logic                    chip_q, perr, eerr;
  logic [2:0]              we_s;
  logic [7:0]              mem  [DEPTH];
  logic [7:0]              pbuf [PAGE_BYTES];

  wire       wr   = we_s[1] & ~we_s[2] & ~ce_n & oe_n;
  wire       busy = (st == S_PROG) || (st == S_ERASE);
  wire       done = busy && (cnt == '0);
  wire [7:0] sr   = {~busy, st == S_SUSP, eerr, perr, 4'h0};

  always_comb begin
    if (ce_n || oe_n)  dout = 8'h00;
    else if (busy)     dout = sr;
    else begin
      case (md)
        M_ARR:   dout = mem[addr];
        M_ID:    dout = addr[0] ? DEV_ID : MFR_ID;
        M_STAT:  dout = sr;
        default: dout = pbuf[addr[PG_W-1:0]];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_s <= 3'b111;
    else        we_s <= {we_s[1:0], we_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      md     <= M_ARR;
      cnt    <= '0;
      lcnt   <= '0;
      page_q <= '0;
      blk_q  <= '0;
      chip_q <= 1'b0;
      perr   <= 1'b0;
      eerr   <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      for (int j = 0; j < PAGE_BYTES; j++) pbuf[j] <= 8'hFF;
    end else begin
      case (st)
        S_IDLE: if (wr) begin
          case (din)
            8'hFF: md <= M_ARR;
            8'h90: md <= M_ID;
            8'h70: md <= M_STAT;
            8'h75: md <= M_BUF;
            8'h41: begin st <= S_LOAD; lcnt <= '0; end
            8'h20: st <= S_ESEL;
            8'hB0, 8'h30: ;
            default: md <= M_ARR;
          endcase
        end
        S_LOAD: if (wr) begin
          pbuf[addr[PG_W-1:0]] <= din;
          page_q <= addr[ADDR_W-1:PG_W];
          lcnt   <= lcnt + 1'b1;
          if (lcnt == PG_W'(PAGE_BYTES - 1)) st <= S_CONF;
        end
        S_CONF: if (wr) begin
          if (din == 8'hD0) begin
            st   <= S_PROG;
            cnt  <= CNT_W'(PROG_CYC - 1);
            md   <= M_STAT;
            perr <= 1'b0;
            eerr <= 1'b0;
          end else begin
            st <= S_IDLE;
            md <= M_ARR;
          end
        end
        S_ESEL: if (wr) begin
          if (din == 8'hD0 || din == 8'h10) begin
            st     <= S_ERASE;
            cnt    <= CNT_W'(ERASE_CYC - 1);
            md     <= M_STAT;
            chip_q <= (din == 8'h10);
            blk_q  <= addr[ADDR_W-1:BK_W];
            perr   <= 1'b0;
            eerr   <= 1'b0;
          end else begin
            st <= S_IDLE;
            md <= M_ARR;
          end
        end
        S_PROG: begin
          if (done) begin
            if (!fail_inject)
              for (int j = 0; j < PAGE_BYTES; j++)
                mem[{page_q, PG_W'(j)}] <= pbuf[j];
            perr <= fail_inject;
            st   <= S_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        S_ERASE: begin
          if (done) begin
            if (!fail_inject)
              for (int i = 0; i < DEPTH; i++)
                if (chip_q || (ADDR_W-BK_W)'(i >> BK_W) == blk_q) mem[i] <= 8'hFF;
            eerr <= fail_inject;
            st   <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
            if (wr && din == 8'hB0) st <= S_SUSP;
          end
        end
        S_SUSP: if (wr) begin
          case (din)
            8'hFF: md <= M_ARR;
            8'h70: md <= M_STAT;
            8'h30: begin st <= S_ERASE; md <= M_STAT; end
            default: ;
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr,
  input logic [7:0]    din,
  input logic [2:0]    st,
  input logic [CW-1:0] cnt,
  input logic [7:0]    sr,
  input logic          fail_inject
);
  assert_stray_codes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && st == 3'd0 && (din == 8'hB0 || din == 8'h30)) |=> (st == 3'd0) && $stable(sr));

  assert_suspend_enter_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && st == 3'd5 && din == 8'hB0 && cnt != '0) |=> (st == 3'd6) && sr[7] && sr[6]);

  assert_suspend_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd6) |=> (st != 3'd6) || $stable(cnt));

  assert_ready_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr[7]) |-> $past(wr));

  assert_busy_discard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && st == 3'd4 && cnt != '0) |=> (st == 3'd4));

  assert_fail_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd4 && cnt == '0) |=> (sr[4] == $past(fail_inject)) && sr[7]);
endmodule

bind flash_cmd_ctrl flash_cmd_chk #(.CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr(wr), .din(din), .st(st),
  .cnt(cnt), .sr(sr), .fail_inject(fail_inject)
);

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
  localparam int AW = 8, PB = 16, BB = 64, PC = 40, EC = 80;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1, fail_inject = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .PAGE_BYTES(PB), .BLOCK_BYTES(BB),
    .PROG_CYC(PC), .ERASE_CYC(EC), .MFR_ID(8'hA5), .DEV_ID(8'h3C)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .fail_inject(fail_inject), .dout(dout));

  function automatic logic [7:0] pat(int a);
    return 8'(a * 7 + 3);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic chk_true(string req, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ctl(int a, logic [7:0] d, logic cen, logic oen);
    @(negedge clk);
    addr = AW'(a); din = d; ce_n = cen; oe_n = oen; we_n = 0;
    repeat (3) @(negedge clk);
    we_n = 1;
    repeat (4) @(negedge clk);
    ce_n = 1; oe_n = 1;
  endtask

  task automatic bw(int a, logic [7:0] d);
    wr_ctl(a, d, 1'b0, 1'b1);
  endtask

  task automatic rd(int a, output logic [7:0] v);
    @(negedge clk);
    addr = AW'(a); ce_n = 0; oe_n = 0;
    #2 v = dout;
    ce_n = 1; oe_n = 1;
  endtask

  task automatic wait_ready(output int n);
    logic [7:0] v;
    n = 0;
    rd(0, v);
    while (!v[7] && n < 1000) begin
      n++;
      rd(0, v);
    end
  endtask

  task automatic load_page(int p);
    bw(p * PB, 8'h41);
    for (int i = 0; i < PB; i++) bw(p * PB + i, pat(p * PB + i));
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(0, v);   chk("R1 array after reset", v, 8'hFF);
    rd(200, v); chk("R1 array after reset", v, 8'hFF);
    bw(0, 8'h70);
    rd(0, v);   chk("R1 status after reset", v, 8'h80);
  endtask

  task automatic t_modes;
    logic [7:0] v;
    bw(0, 8'h90);
    rd(0, v); chk("R2 manufacturer id", v, 8'hA5);
    rd(1, v); chk("R2 device id", v, 8'h3C);
    @(negedge clk); addr = 0; ce_n = 0; oe_n = 1;
    #2 chk("R2 output disabled", dout, 8'h00);
    ce_n = 1;
  endtask

  task automatic t_strobe;
    logic [7:0] v;
    bw(0, 8'h70);
    wr_ctl(0, 8'hFF, 1'b1, 1'b1);
    rd(5, v); chk("R3 ce_n high write ignored", v, 8'h80);
    wr_ctl(0, 8'hFF, 1'b0, 1'b0);
    rd(5, v); chk("R3 oe_n low write ignored", v, 8'h80);
    bw(0, 8'hFF);
    rd(5, v); chk("R3 valid write to array", v, 8'hFF);
  endtask

  task automatic t_program(int p);
    logic [7:0] v;
    int n;
    load_page(p);
    bw(p * PB, 8'hD0);
    rd(0, v); chk("R5 busy status", v, 8'h00);
    bw(0, 8'hFF);
    rd(p * PB, v); chk("R10 write during program discarded", v, 8'h00);
    wait_ready(n);
    chk_true("R5 program duration", n >= PC - 14 && n <= PC, n, PC);
    rd(p * PB, v); chk("R5 status mode after program", v, 8'h80);
    bw(0, 8'hFF);
    for (int i = 0; i < PB; i += 5) begin
      rd(p * PB + i, v); chk("R4 programmed byte", v, pat(p * PB + i));
    end
    rd(p * PB + PB, v);   chk("R4 next page untouched", v, (p == 3 || p == 15) ? v : 8'hFF);
    bw(0, 8'h75);
    rd(3, v); chk("R4 page buffer read", v, pat(p * PB + 3));
  endtask

  task automatic t_bad;
    logic [7:0] v;
    load_page(2);
    bw(32, 8'h55);
    rd(32, v); chk("R7 bad confirm to array, not programmed", v, 8'hFF);
    bw(0, 8'h70);
    bw(0, 8'h20);
    bw(16, 8'h77);
    rd(16, v); chk("R7 bad erase byte to array", v, pat(16));
    bw(0, 8'h70);
    bw(0, 8'h12);
    rd(16, v); chk("R7 unknown code to array", v, pat(16));
  endtask

  task automatic t_stray;
    logic [7:0] v;
    bw(0, 8'h70);
    bw(0, 8'hB0);
    rd(0, v); chk("R8 suspend ignored when idle", v, 8'h80);
    bw(0, 8'h30);
    rd(0, v); chk("R8 resume ignored when idle", v, 8'h80);
    bw(0, 8'hFF);
    bw(0, 8'hB0);
    rd(16, v); chk("R8 array mode kept", v, pat(16));
  endtask

  task automatic t_erase_block;
    logic [7:0] v;
    int n;
    bw(0, 8'h20);
    bw(20, 8'hD0);
    wait_ready(n);
    chk_true("R5 erase duration", n >= EC - 14 && n <= EC, n, EC);
    bw(0, 8'hFF);
    rd(16, v); chk("R6 block erased", v, 8'hFF);
    rd(31, v); chk("R6 block erased", v, 8'hFF);
    rd(64, v); chk("R6 other block kept", v, pat(64));
  endtask

  task automatic t_suspend;
    logic [7:0] v;
    int n;
    bw(0, 8'h20);
    bw(0, 8'h10);
    repeat (6) @(negedge clk);
    bw(0, 8'hB0);
    rd(0, v); chk("R9 suspended status", v, 8'hC0);
    repeat (2 * EC) @(negedge clk);
    rd(0, v); chk("R9 still suspended", v, 8'hC0);
    bw(0, 8'hFF);
    rd(64, v); chk("R9 array readable in suspend", v, pat(64));
    bw(0, 8'h41);
    rd(65, v); chk("R9 other command ignored in suspend", v, pat(65));
    bw(0, 8'h30);
    rd(0, v); chk("R9 resumed busy", v, 8'h00);
    wait_ready(n);
    chk_true("R9 remaining count only", n > 0 && n < EC - 10, n, EC - 20);
    rd(0, v); chk("R9 flag cleared", v, 8'h80);
    bw(0, 8'hFF);
    rd(64, v); chk("R6 chip erased", v, 8'hFF);
  endtask

  task automatic t_fail;
    logic [7:0] v;
    int n;
    fail_inject = 1;
    load_page(2);
    bw(32, 8'hD0);
    wait_ready(n);
    rd(0, v); chk("R11 program fail flag", v, 8'h90);
    bw(0, 8'hFF);
    rd(32, v); chk("R11 array unchanged on fail", v, 8'hFF);
    bw(0, 8'h20);
    bw(64, 8'hD0);
    wait_ready(n);
    rd(0, v); chk("R11 erase fail flag", v, 8'hA0);
    fail_inject = 0;
    load_page(2);
    bw(32, 8'hD0);
    wait_ready(n);
    rd(0, v); chk("R11 flags cleared", v, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_modes();
    t_strobe();
    t_program(1);
    t_program(4);
    t_bad();
    t_stray();
    t_erase_block();
    t_suspend();
    t_fail();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule